// File: doc/BRIEF.md
# Audio Serial Controller Status and Interrupt Bank

This block holds the status flags and interrupt masking of an audio serial controller and drives its single interrupt line. The transmitter and receiver report overrun and underrun as one-cycle event pulses, each tagged with the channel it hit. Each pulse sets a sticky summary flag and a sticky flag for that channel. The ready and enabled conditions arrive as levels and are shown live in the status word.

Software reaches the bank over a simple word bus with 32-bit registers on a 4-byte stride. The two low address bits are ignored. Sticky flags are cleared through one write-one register and forced through another. The interrupt mask is changed only through a pair of enable and disable registers and can be read back. The interrupt line is high whenever any status bit is also set in the mask.

Top module: `audio_stat_irq_bank`

## Requirements
- R1: After reset every sticky flag and every mask bit is zero and `irq` is low.
- R2: The status word at byte offset 0x08 shows `rx_enabled` at bit 0, `rx_ready` at bit 1, `tx_enabled` at bit 4 and `tx_ready` at bit 5 as live levels.
- R3: A pulse on `rx_ovr_evt` sets status bit 2 and bit 8+`rx_ovr_ch`. Both stay set until they are cleared.
- R4: A pulse on `tx_und_evt` sets status bit 6 and bit 20+`tx_und_ch`. Both stay set until they are cleared.
- R5: Writing to offset 0x0C clears each sticky flag (bits 2, 6, 15:8, 27:20) that has a one in the data. Sticky flags with a zero in the data are kept.
- R6: Writing to offset 0x10 sets each sticky flag that has a one in the data. The live level bits are not changed by this write.
- R7: Writing to offset 0x14 sets mask bits and writing to offset 0x18 clears mask bits. Only bits 1, 2, 5 and 6 exist. The mask reads back at offset 0x1C, and writes to 0x1C are ignored.
- R8: `irq` is high exactly when the bitwise AND of status and mask is non-zero. It follows a mask or sticky change at the clock edge that makes the change.
- R9: When an event sets a flag in the same cycle that a 0x0C write clears it, the flag ends up set.
- R10: Reads of offsets 0x0C, 0x10, 0x14 and 0x18, and of any unmapped offset, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe for the register at `bus_addr` |
| bus_addr | input | 8 | Byte address; the low two bits are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| rx_enabled | input | 1 | Receiver enabled level |
| rx_ready | input | 1 | Receive data ready level |
| tx_enabled | input | 1 | Transmitter enabled level |
| tx_ready | input | 1 | Transmit holding ready level |
| rx_ovr_evt | input | 1 | Receive overrun pulse |
| rx_ovr_ch | input | 3 | Channel of the receive overrun |
| tx_und_evt | input | 1 | Transmit underrun pulse |
| tx_und_ch | input | 3 | Channel of the transmit underrun |
| irq | output | 1 | Interrupt request |

## Verification
A sticky flag that is lost or misplaced shows up on the status read in the cycle after its event. If the flag is an interrupt source, it also shows on `irq` in that same cycle. A mask bit that is wrong is visible at once on the 0x1C read, and it changes `irq` only once a matching status bit is present. For that reason the mask is checked against both a live level source and a sticky source. The race between a set and a clear is left alone in every normal pattern, so it is tested directly by driving both in one cycle.

// File: rtl/audio_stat_pkg.sv
package audio_stat_pkg;
  localparam int REG_W   = 32;
  localparam int MAX_CH  = 8;
  // byte offsets
  localparam logic [7:0] OFF_STAT  = 8'h08;
  localparam logic [7:0] OFF_CLR   = 8'h0C;
  localparam logic [7:0] OFF_SET   = 8'h10;
  localparam logic [7:0] OFF_IEN   = 8'h14;
  localparam logic [7:0] OFF_IDIS  = 8'h18;
  localparam logic [7:0] OFF_IMASK = 8'h1C;
  // bit positions
  localparam int B_RXEN  = 0;
  localparam int B_RXRDY = 1;
  localparam int B_RXOVR = 2;
  localparam int B_TXEN  = 4;
  localparam int B_TXRDY = 5;
  localparam int B_TXUND = 6;
  localparam int RXCH_LSB = 8;
  localparam int TXCH_LSB = 20;

  function automatic logic [REG_W-1:0] sticky_bits(input int nch);
    logic [REG_W-1:0] m;
    m = '0;
    m[B_RXOVR] = 1'b1;
    m[B_TXUND] = 1'b1;
    for (int c = 0; c < nch; c++) begin
      m[RXCH_LSB + c] = 1'b1;
      m[TXCH_LSB + c] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [REG_W-1:0] irq_src_bits();
    logic [REG_W-1:0] m;
    m = '0;
    m[B_RXRDY] = 1'b1;
    m[B_RXOVR] = 1'b1;
    m[B_TXRDY] = 1'b1;
    m[B_TXUND] = 1'b1;
    return m;
  endfunction

  function automatic logic [REG_W-1:0] level_word(input logic rxe, input logic rxr,
                                                  input logic txe, input logic txr);
    logic [REG_W-1:0] w;
    w = '0;
    w[B_RXEN]  = rxe;
    w[B_RXRDY] = rxr;
    w[B_TXEN]  = txe;
    w[B_TXRDY] = txr;
    return w;
  endfunction
endpackage

// File: rtl/stat_sticky_bank.sv
module stat_sticky_bank #(
  parameter int W = 32,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  for (genvar b = 0; b < W; b++) begin : g_bit
    if (IMPL[b]) begin : g_flop
      always_ff @(posedge clk) begin
        if (!rst_n)        q[b] <= 1'b0;
        else if (set_i[b]) q[b] <= 1'b1;
        else if (clr_i[b]) q[b] <= 1'b0;
      end
      // R9
      set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i[b] |=> q[b]);
      // R5
      clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i[b] && !set_i[b]) |=> !q[b]);
    end else begin : g_tie
      assign q[b] = 1'b0;
    end
  end

  assign q_o = q;
endmodule

// File: rtl/stat_mask_bank.sv
module stat_mask_bank #(
  parameter int W = 32,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_we,
  input  logic         dis_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      mask_q <= '0;
    else if (en_we)  mask_q <= mask_q | (wdata & IMPL);
    else if (dis_we) mask_q <= mask_q & ~wdata;
  end

  assign mask_o = mask_q;

  // R7
  mask_impl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q & ~IMPL) == '0);
  // R7
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_we && !dis_we) |=> $stable(mask_q));
endmodule

// File: rtl/stat_read_mux.sv
module stat_read_mux #(
  parameter int ADDR_W = 8,
  parameter int W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      status,
  input  logic [W-1:0]      mask,
  output logic [W-1:0]      rdata
);
  import audio_stat_pkg::*;
  logic [ADDR_W-1:0] word_addr;

  assign word_addr = {addr[ADDR_W-1:2], 2'b00};

  always_comb begin
    rdata = '0;
    if (word_addr == ADDR_W'(OFF_STAT))       rdata = status;
    else if (word_addr == ADDR_W'(OFF_IMASK)) rdata = mask;
  end
endmodule

// File: rtl/audio_stat_irq_bank.sv
module audio_stat_irq_bank #(
  parameter int ADDR_W = 8,
  parameter int NUM_CH = 8,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              rx_enabled,
  input  logic              rx_ready,
  input  logic              tx_enabled,
  input  logic              tx_ready,
  input  logic              rx_ovr_evt,
  input  logic [CH_W-1:0]   rx_ovr_ch,
  input  logic              tx_und_evt,
  input  logic [CH_W-1:0]   tx_und_ch,
  output logic              irq
);
  import audio_stat_pkg::*;
  localparam logic [REG_W-1:0] STICKY = sticky_bits(NUM_CH);
  localparam logic [REG_W-1:0] IRQSRC = irq_src_bits();

  logic [ADDR_W-1:0] word_addr;
  logic wr_clr, wr_set, wr_ien, wr_idis;
  logic [REG_W-1:0] evt_set, sw_set, sw_clr, sticky_q, mask_q, status_w, pending_w;

  assign word_addr = {bus_addr[ADDR_W-1:2], 2'b00};
  assign wr_clr  = bus_we && (word_addr == ADDR_W'(OFF_CLR));
  assign wr_set  = bus_we && (word_addr == ADDR_W'(OFF_SET));
  assign wr_ien  = bus_we && (word_addr == ADDR_W'(OFF_IEN));
  assign wr_idis = bus_we && (word_addr == ADDR_W'(OFF_IDIS));

  always_comb begin
    evt_set = '0;
    if (rx_ovr_evt) begin
      evt_set[B_RXOVR] = 1'b1;
      evt_set[RXCH_LSB + int'(rx_ovr_ch)] = 1'b1;
    end
    if (tx_und_evt) begin
      evt_set[B_TXUND] = 1'b1;
      evt_set[TXCH_LSB + int'(tx_und_ch)] = 1'b1;
    end
  end

  assign sw_set = wr_set ? (bus_wdata & STICKY) : '0;
  assign sw_clr = wr_clr ? (bus_wdata & STICKY) : '0;

  stat_sticky_bank #(.W(REG_W), .IMPL(STICKY)) i_sticky (
    .clk(clk), .rst_n(rst_n), .set_i(evt_set | sw_set), .clr_i(sw_clr), .q_o(sticky_q));

  stat_mask_bank #(.W(REG_W), .IMPL(IRQSRC)) i_mask (
    .clk(clk), .rst_n(rst_n), .en_we(wr_ien), .dis_we(wr_idis),
    .wdata(bus_wdata), .mask_o(mask_q));

  assign status_w  = sticky_q | level_word(rx_enabled, rx_ready, tx_enabled, tx_ready);
  assign pending_w = status_w & mask_q;
  assign irq       = |pending_w;

  stat_read_mux #(.ADDR_W(ADDR_W), .W(REG_W)) i_rmux (
    .addr(bus_addr), .status(status_w), .mask(mask_q), .rdata(bus_rdata));

  // R3
  rx_ovr_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovr_evt |=> sticky_q[B_RXOVR]);
  // R4
  tx_und_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_und_evt |=> sticky_q[B_TXUND]);
  // R8
  irq_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);
  // R10
  wo_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_addr == ADDR_W'(OFF_CLR) || word_addr == ADDR_W'(OFF_SET) ||
     word_addr == ADDR_W'(OFF_IEN) || word_addr == ADDR_W'(OFF_IDIS)) |-> bus_rdata == '0);
  // R6
  set_keeps_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_set && !rx_enabled) |=> (!rx_enabled -> !bus_rdata[B_RXEN] || word_addr != ADDR_W'(OFF_STAT)));
endmodule

// File: tb/test_audio_stat_irq_bank.sv
`timescale 1ns/100ps
module test_audio_stat_irq_bank;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic rx_enabled = 0, rx_ready = 0, tx_enabled = 0, tx_ready = 0;
  logic rx_ovr_evt = 0, tx_und_evt = 0;
  logic [2:0] rx_ovr_ch = 0, tx_und_ch = 0;
  logic irq;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  audio_stat_irq_bank i_audio_stat_irq_bank (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_enabled(rx_enabled),
    .rx_ready(rx_ready), .tx_enabled(tx_enabled), .tx_ready(tx_ready),
    .rx_ovr_evt(rx_ovr_evt), .rx_ovr_ch(rx_ovr_ch), .tx_und_evt(tx_und_evt),
    .tx_und_ch(tx_und_ch), .irq(irq));

  // {write, tag, addr, data/expected}
  localparam int NV = 16;
  localparam logic [44:0] VEC [0:NV-1] = '{
    {1'b0, 4'd1,  8'h08, 32'h0000_0000},
    {1'b0, 4'd1,  8'h1C, 32'h0000_0000},
    {1'b1, 4'd6,  8'h10, 32'hFFFF_FFFF},
    {1'b0, 4'd6,  8'h08, 32'h0FF0_FF44},
    {1'b1, 4'd5,  8'h0C, 32'h0000_0F04},
    {1'b0, 4'd5,  8'h08, 32'h0FF0_F040},
    {1'b1, 4'd7,  8'h14, 32'hFFFF_FFFF},
    {1'b0, 4'd7,  8'h1C, 32'h0000_0066},
    {1'b1, 4'd7,  8'h18, 32'h0000_0022},
    {1'b1, 4'd7,  8'h1C, 32'h0000_0000},
    {1'b0, 4'd7,  8'h1E, 32'h0000_0044},
    {1'b0, 4'd10, 8'h0C, 32'h0000_0000},
    {1'b0, 4'd10, 8'h10, 32'h0000_0000},
    {1'b0, 4'd10, 8'h14, 32'h0000_0000},
    {1'b0, 4'd10, 8'h18, 32'h0000_0000},
    {1'b0, 4'd10, 8'h40, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 irq", {31'd0, irq}, 32'd0);
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][44]) wr(VEC[i][39:32], VEC[i][31:0]);
      else begin
        @(negedge clk);
        rd($sformatf("R%0d vec%0d", VEC[i][43:40], i), VEC[i][39:32], VEC[i][31:0]);
      end
    end
    // mask is now 0x44, no sticky flags after clearing
    wr(8'h0C, 32'hFFFF_FFFF);
    rd("R5 clear all", 8'h08, 32'h0);
    // R2 levels, R8 irq from level source
    @(negedge clk);
    rx_enabled = 1; tx_ready = 1;
    rd("R2 levels", 8'h08, 32'h0000_0021);
    check("R8 tx_ready unmasked", {31'd0, irq}, 32'd0);
    wr(8'h14, 32'h0000_0020);
    check("R8 tx_ready masked", {31'd0, irq}, 32'd1);
    wr(8'h18, 32'h0000_0020);
    check("R8 after disable", {31'd0, irq}, 32'd0);
    tx_ready = 0;
    // R6 set write does not touch level bits
    wr(8'h10, 32'h0000_0011);
    rd("R6 level untouched", 8'h08, 32'h0000_0001);
    // R3 overrun on channel 3
    @(negedge clk);
    rx_ovr_evt = 1; rx_ovr_ch = 3;
    @(negedge clk);
    rx_ovr_evt = 0;
    rd("R3 overrun ch3", 8'h08, 32'h0000_0805);
    check("R8 overrun irq", {31'd0, irq}, 32'd1);
    // R4 underrun on channel 7
    @(negedge clk);
    tx_und_evt = 1; tx_und_ch = 7;
    @(negedge clk);
    tx_und_evt = 0;
    rd("R4 underrun ch7", 8'h08, 32'h0800_0845);
    repeat (3) @(negedge clk);
    rd("R3 sticky hold", 8'h08, 32'h0800_0845);
    wr(8'h0C, 32'hFFFF_FFFF);
    rd("R5 cleared", 8'h08, 32'h0000_0001);
    check("R8 irq drops", {31'd0, irq}, 32'd0);
    // R9 set wins against same-cycle clear
    @(negedge clk);
    rx_ovr_evt = 1; rx_ovr_ch = 0;
    bus_we = 1; bus_addr = 8'h0C; bus_wdata = 32'h0000_0104;
    @(negedge clk);
    rx_ovr_evt = 0; bus_we = 0;
    rd("R9 set wins", 8'h08, 32'h0000_0105);
    // R1 reset mid-run
    @(negedge clk);
    rst_n = 0; rx_enabled = 0;
    @(negedge clk);
    rst_n = 1;
    rd("R1 status after reset", 8'h08, 32'h0);
    rd("R1 mask after reset", 8'h1C, 32'h0);
    check("R1 irq after reset", {31'd0, irq}, 32'd0);
    finish_run();
  end
endmodule